// File: doc/BRIEF.md
# Two-Digit Hex Seven-Segment Multiplex Driver

This block shows an 8-bit value as two hexadecimal digits on a seven-segment display that has one shared segment bus. A slow select signal is produced elsewhere from the system clock, at a rate of a few hundred toggles per second. The same signal drives the display's digit-enable line and this block's select input. When select is low, the right-hand digit is lit and the block decodes the low nibble. When select is high, the left-hand digit is lit and the block decodes the high nibble. The digits alternate fast enough that both appear lit at once.

One select level chooses both the nibble and the digit. The block registers the decoded segments and its copy of the digit select on the same clock edge, so the pattern on the bus always belongs to the digit marked as active. A parameter sets the segment polarity for common-cathode or common-anode wiring.

Top module: `dual_digit_seg_drv`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next edge leaves all segments dark: `seg_o` is 7'h00 with ACTIVE_LOW=0 and 7'h7F with ACTIVE_LOW=1. `dig_left_o` is 0.
- R2: Outputs are registered with one cycle of latency. `seg_o` and `dig_left_o` reflect `sel_i` and `val_i` as sampled at the previous rising edge. A change to the inputs between edges does not alter the outputs.
- R3: With `sel_i` low, `dig_left_o` becomes 0 and `seg_o` shows the glyph of `val_i[3:0]`.
- R4: With `sel_i` high, `dig_left_o` becomes 1 and `seg_o` shows the glyph of `val_i[7:4]`.
- R5: Segment a maps to bit 0 and segment g to bit 6. The active-high glyph codes are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F A:77 b:7C C:39 d:5E E:79 F:71.
- R6: With ACTIVE_LOW=1, every `seg_o` bit is the inverse of the active-high value for the same inputs.
- R7: The nibble that is not selected has no effect on `seg_o`.
- R8: Out of reset, every glyph lights at least two segments, so a running display is never dark.
- R9: `dig_left_o` and `seg_o` change on the same edge. A select toggle never yields a cycle where the new digit shows the old digit's glyph.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Slow digit select: 0 = right/low nibble, 1 = left/high nibble |
| val_i | input | 8 | Value to display as two hex digits |
| seg_o | output | 7 | Segment bus, bit 0 = a through bit 6 = g |
| dig_left_o | output | 1 | Registered digit select, 1 = left digit active |

## Verification
The hardest case to reach is a select edge in the same cycle that the value also changes. A lag between the digit select and the segment register would show up only there, as one cycle where the new digit carries the stale glyph. The bench toggles `sel_i` on every clock while it rewrites `val_i` with distinct patterns. It checks each cycle that the digit output and the glyph both belong to the inputs sampled at that same edge. Separate sweeps hold one nibble fixed and vary the other, so that the unselected nibble can be shown to have no effect.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;
  localparam int SEG_W = 7;
  localparam int HEX_W = 4;
  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [HEX_W-1:0] hex_t;
endpackage

// File: rtl/nibble_pick.sv
module nibble_pick #(
  parameter int NIB_W  = 4,
  parameter int NUM_NB = 2
) (
  input  logic [NIB_W*NUM_NB-1:0] val_i,
  input  logic                    sel_i,
  output logic [NIB_W-1:0]        nib_o
);
  logic [NIB_W-1:0] nibs [NUM_NB];

  for (genvar g = 0; g < NUM_NB; g++) begin : g_split
    assign nibs[g] = val_i[g*NIB_W +: NIB_W];
  end

  // select low -> nibble 0 (right), select high -> nibble 1 (left)
  assign nib_o = sel_i ? nibs[1] : nibs[0];
endmodule

// File: rtl/hex_glyph_dec.sv
module hex_glyph_dec
  import segdisp_pkg::*;
(
  input  hex_t nib_i,
  output seg_t seg_o   // active high, bit0 = a .. bit6 = g
);
  always_comb begin
    unique case (nib_i)
      4'h0: seg_o = 7'h3F;
      4'h1: seg_o = 7'h06;
      4'h2: seg_o = 7'h5B;
      4'h3: seg_o = 7'h4F;
      4'h4: seg_o = 7'h66;
      4'h5: seg_o = 7'h6D;
      4'h6: seg_o = 7'h7D;
      4'h7: seg_o = 7'h07;
      4'h8: seg_o = 7'h7F;
      4'h9: seg_o = 7'h6F;
      4'hA: seg_o = 7'h77;
      4'hB: seg_o = 7'h7C;
      4'hC: seg_o = 7'h39;
      4'hD: seg_o = 7'h5E;
      4'hE: seg_o = 7'h79;
      default: seg_o = 7'h71;
    endcase
  end
endmodule

// File: rtl/seg_polarity.sv
module seg_polarity
  import segdisp_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  seg_t seg_hi_i,
  output seg_t seg_o
);
  if (ACTIVE_LOW) begin : g_low
    assign seg_o = ~seg_hi_i;
  end else begin : g_high
    assign seg_o = seg_hi_i;
  end
endmodule

// File: rtl/dual_digit_seg_drv.sv
module dual_digit_seg_drv
  import segdisp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] val_i,
  output logic [SEG_W-1:0]  seg_o,
  output logic              dig_left_o
);
  localparam int   NUM_DIG = DATA_W / HEX_W;
  localparam seg_t BLANK   = ACTIVE_LOW ? {SEG_W{1'b1}} : {SEG_W{1'b0}};

  hex_t nib;
  seg_t seg_hi;
  seg_t seg_pol;
  seg_t seg_q;
  logic left_q;

  nibble_pick #(.NIB_W(HEX_W), .NUM_NB(NUM_DIG)) u_pick (
    .val_i (val_i),
    .sel_i (sel_i),
    .nib_o (nib)
  );

  hex_glyph_dec u_dec (
    .nib_i (nib),
    .seg_o (seg_hi)
  );

  seg_polarity #(.ACTIVE_LOW(ACTIVE_LOW)) u_pol (
    .seg_hi_i (seg_hi),
    .seg_o    (seg_pol)
  );

  // segments and digit select share one register stage (R9)
  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q  <= BLANK;
      left_q <= 1'b0;
    end else begin
      seg_q  <= seg_pol;
      left_q <= sel_i;
    end
  end

  assign seg_o      = seg_q;
  assign dig_left_o = left_q;

  AST_RST_BLANK: assert property (@(posedge clk)
    rst |=> (seg_o == BLANK && !dig_left_o)); // R1

  AST_SEL_LATENCY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dig_left_o == $past(sel_i))); // R2

  AST_NEVER_DARK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(seg_o ^ BLANK) >= 2)); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(sel_i) && $stable(val_i)) |=>
      ($stable(seg_o) && $stable(dig_left_o))); // R9

  AST_OTHER_NIB: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(sel_i) && !sel_i && $stable(val_i[3:0])) |=>
      $stable(seg_o)); // R7
endmodule

// File: tb/tb_dual_digit_seg_drv.sv
module tb_dual_digit_seg_drv;
  logic       clk = 1'b0;
  logic       rst;
  logic       sel;
  logic [7:0] val;
  logic [6:0] seg, seg_n;
  logic       left, left_n;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dual_digit_seg_drv #(.DATA_W(8), .ACTIVE_LOW(1'b0)) dut (
    .clk(clk), .rst(rst), .sel_i(sel), .val_i(val),
    .seg_o(seg), .dig_left_o(left));

  dual_digit_seg_drv #(.DATA_W(8), .ACTIVE_LOW(1'b1)) dut_inv (
    .clk(clk), .rst(rst), .sel_i(sel), .val_i(val),
    .seg_o(seg_n), .dig_left_o(left_n));

  function automatic logic [6:0] glyph(input logic [3:0] n);
    case (n)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, then sample 1 ns after the following rising edge
  task automatic apply(input logic s, input logic [7:0] v);
    @(negedge clk);
    sel = s;
    val = v;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1; sel = 1'b1; val = 8'h88;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 seg", {1'b0, seg}, 8'h00);
    chk("R1 left", {7'b0, left}, 8'h00);
    chk("R1 seg inv", {1'b0, seg_n}, 8'h7F);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_sweep(input logic s);
    for (int v = 0; v < 256; v++) begin
      logic [7:0] vv = 8'(v);
      apply(s, vv);
      if (!s) begin
        chk("R3 R5 right glyph", {1'b0, seg}, {1'b0, glyph(vv[3:0])});
        chk("R3 digit", {7'b0, left}, 8'h00);
      end else begin
        chk("R4 R5 left glyph", {1'b0, seg}, {1'b0, glyph(vv[7:4])});
        chk("R4 digit", {7'b0, left}, 8'h01);
      end
      chk("R6 inverted", {1'b0, seg_n}, {1'b0, ~glyph(s ? vv[7:4] : vv[3:0])});
      chk("R8 lit count", 8'($countones(seg)), ($countones(seg) >= 2) ? 8'($countones(seg)) : 8'd2);
    end
  endtask

  task automatic t_other_ignored();
    for (int u = 0; u < 16; u++) begin
      apply(1'b0, {4'(u), 4'h5});
      chk("R7 upper ignored", {1'b0, seg}, {1'b0, 7'h6D});
    end
    for (int l = 0; l < 16; l++) begin
      apply(1'b1, {4'hC, 4'(l)});
      chk("R7 lower ignored", {1'b0, seg}, {1'b0, 7'h39});
    end
  endtask

  task automatic t_latency();
    apply(1'b0, 8'h21);
    @(negedge clk);
    sel = 1'b1; val = 8'hE7;
    #1;
    chk("R2 no change before edge", {1'b0, seg}, {1'b0, 7'h06});
    chk("R2 digit held", {7'b0, left}, 8'h00);
    @(posedge clk); #1;
    chk("R2 after edge", {1'b0, seg}, {1'b0, 7'h79});
  endtask

  task automatic t_align();
    logic [7:0] pat [4] = '{8'h3A, 8'hF0, 8'h96, 8'h4D};
    for (int i = 0; i < 16; i++) begin
      logic s = i[0];
      logic [7:0] v = pat[i % 4];
      apply(s, v);
      chk("R9 digit", {7'b0, left}, {7'b0, s});
      chk("R9 glyph", {1'b0, seg}, {1'b0, glyph(s ? v[7:4] : v[3:0])});
    end
  endtask

  initial begin
    t_reset();
    t_sweep(1'b0);
    t_sweep(1'b1);
    t_other_ignored();
    t_latency();
    t_align();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule